// File: doc/BRIEF.md
# UART Hardware Flow Control Unit

This block holds the handshake logic around an asynchronous serial port that has a single transmit holding register and a single receive buffer register. One handshake input pin and one handshake output pin are shared. Each pin's meaning is chosen by a control bit. The input pin either permits the transmitter to begin frames (clear-to-send) or permits the receiver to accept frames (enable-receiver). The output pin either signals that untransmitted data is waiting (ready-to-send) or that the receive buffer is free (ready-to-receive). A master enable switches all handshaking off. When it is off, both directions run freely and the output pin rests inactive.

The input pin is asynchronous, so it passes through a two-flop synchronizer before it is used. The transmitter looks at the synchronized clear-to-send only at the moment a new frame would begin. A frame that has already started always runs to its end. A plain start/data/stop frame shifter on each side stands in for the real serializer, so that the gating can be observed on the serial lines.

Top module: `uart_flow_ctl`

## Requirements
- R1: While `rst_n` is low, `hs_out_n` and `tx_line` are high, and `tx_hold_full`, `tx_busy` and `rx_valid` are low.
- R2: With `fc_en`=1 and `in_mode`=0 (clear-to-send), a full holding register begins a frame only while the synchronized `hs_in_n` is low. While `hs_in_n` is high, `tx_hold_full` stays 1 and `tx_line` stays idle high.
- R3: Clear-to-send is evaluated only when a frame would begin. A frame in progress completes unchanged if `hs_in_n` rises during it.
- R4: A transmit frame is a start bit of 0, then DATA_W data bits LSB first, then a stop bit of 1. Each bit lasts BIT_CYC clocks. Loading the shifter clears `tx_hold_full`, and `tx_line` is high whenever `tx_busy` is low.
- R5: With `fc_en`=1 and `in_mode`=1 (enable-receiver), the receiver begins no new frame while the synchronized `hs_in_n` is high, and the transmitter is not gated by the pin.
- R6: A received frame that the receiver has begun sets `rx_valid` and presents its data bits on `rx_data`. The data bits arrive in the same format as R4, with the first bit received placed at bit 0. An `rx_rd` pulse clears `rx_valid`.
- R7: With `fc_en`=1 and `out_mode`=1 (ready-to-send), `hs_out_n` is low exactly when `tx_hold_full` was 1 on the previous clock.
- R8: With `fc_en`=1 and `out_mode`=0 (ready-to-receive), `hs_out_n` is low exactly when `rx_valid` was 0 on the previous clock.
- R9: With `fc_en`=0, `hs_out_n` is high, the transmitter begins frames whatever `hs_in_n` is, and the receiver accepts frames whatever `hs_in_n` is.
- R10: A change of `hs_in_n` driven before clock edge n is first acted on at edge n+2. A frame start that it permits appears as `tx_busy` high after edge n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fc_en | input | 1 | Flow-control enable |
| in_mode | input | 1 | Input pin role: 0 clear-to-send, 1 enable-receiver |
| out_mode | input | 1 | Output pin role: 1 ready-to-send, 0 ready-to-receive |
| hs_in_n | input | 1 | Shared asynchronous handshake input, active low |
| hs_out_n | output | 1 | Shared handshake output, active low, registered |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | DATA_W | Data written to the holding register |
| tx_hold_full | output | 1 | Holding register contains unsent data |
| tx_busy | output | 1 | A transmit frame is on the line |
| tx_line | output | 1 | Serial transmit line, idle high |
| rx_line | input | 1 | Serial receive line, idle high |
| rx_rd | input | 1 | Read strobe that clears the receive-valid flag |
| rx_data | output | DATA_W | Last received data |
| rx_valid | output | 1 | Receive buffer holds unread data |

## Verification
A wrong full or valid flag shows on `hs_out_n` one clock later in the matching output mode. A wrong flag also shows on `tx_busy` at the first frame opportunity, so a stuck flag never stays hidden for more than a frame time. A wrong synchronizer depth or a clear-to-send sampled mid-frame moves the `tx_busy` rise by whole cycles or cuts a frame short, and the bench times both to the edge. A gate applied to the wrong direction shows as a received byte that should have been ignored, or as a held byte that should have gone out.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BITS = 1'b1
  } rx_state_e;

  // Width of a counter that must hold values 0 .. n-1 (at least one bit).
  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d[0] = d;

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      assign chain_d[i] = chain_q[i-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/fc_tx_path.sv
module fc_tx_path
  import uart_fc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              start_ok,
  output logic              hold_full,
  output logic              busy,
  output logic              line
);

  localparam int FW = DATA_W + 2;
  localparam int CW = cnt_w(BIT_CYC);
  localparam int IW = cnt_w(FW);

  tx_state_e         st_q, st_d;
  logic [DATA_W-1:0] hold_q;
  logic              full_q, full_d;
  logic [FW-1:0]     sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              load;
  logic              bit_end;

  assign load    = (st_q == TX_IDLE) && full_q && start_ok;
  assign bit_end = (cnt_q == CW'(BIT_CYC - 1));

  always_comb begin
    st_d   = st_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    full_d = wr | (full_q & ~load);
    case (st_q)
      TX_IDLE: begin
        if (load) begin
          st_d  = TX_SEND;
          sh_d  = {1'b1, hold_q, 1'b0};
          cnt_d = '0;
          idx_d = '0;
        end
      end
      TX_SEND: begin
        if (bit_end) begin
          cnt_d = '0;
          sh_d  = {1'b1, sh_q[FW-1:1]};
          if (idx_q == IW'(FW - 1)) st_d = TX_IDLE;
          else                      idx_d = idx_q + 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      full_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      full_q <= full_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hold_q <= '0;
    else if (wr) hold_q <= wdata;
  end

  assign hold_full = full_q;
  assign busy      = (st_q == TX_SEND);
  assign line      = (st_q == TX_SEND) ? sh_q[0] : 1'b1;

endmodule

// File: rtl/fc_rx_path.sv
module fc_rx_path
  import uart_fc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              rx_en,
  input  logic              rd,
  output logic [DATA_W-1:0] data,
  output logic              valid
);

  localparam int CW = cnt_w(BIT_CYC);
  localparam int IW = cnt_w(DATA_W + 1);

  rx_state_e         st_q, st_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] data_q;
  logic              valid_q, valid_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              bit_end;
  logic              done;

  assign bit_end = (cnt_q == CW'(BIT_CYC - 1));

  always_comb begin
    st_d  = st_q;
    sh_d  = sh_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    done  = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (rx_en && !line) begin
          st_d  = RX_BITS;
          cnt_d = '0;
          idx_d = '0;
        end
      end
      RX_BITS: begin
        if (bit_end) begin
          cnt_d = '0;
          if (idx_q == IW'(DATA_W)) begin
            st_d = RX_IDLE;
            done = 1'b1;
          end else begin
            sh_d  = {line, sh_q[DATA_W-1:1]};
            idx_d = idx_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
    valid_d = done | (valid_q & ~rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (done) data_q <= sh_q;
  end

  assign data  = data_q;
  assign valid = valid_q;

endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int DATA_W      = 8,
  parameter int BIT_CYC     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_en,
  input  logic              in_mode,
  input  logic              out_mode,
  input  logic              hs_in_n,
  output logic              hs_out_n,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_wdata,
  output logic              tx_hold_full,
  output logic              tx_busy,
  output logic              tx_line,
  input  logic              rx_line,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);

  logic rst_n_int;
  logic hs_in_s;
  logic hs_act;
  logic tx_ok;
  logic rx_ok;
  logic hs_out_q, hs_out_d;

  // Reset asserts at once and is released on a clock edge.
  fc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  // The handshake pin rests inactive (high) while in reset.
  fc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hs_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d     (hs_in_n),
    .q     (hs_in_s)
  );

  assign hs_act = ~hs_in_s;
  assign tx_ok  = ~fc_en | in_mode  | hs_act;
  assign rx_ok  = ~fc_en | ~in_mode | hs_act;

  fc_tx_path #(.DATA_W(DATA_W), .BIT_CYC(BIT_CYC)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr        (tx_wr),
    .wdata     (tx_wdata),
    .start_ok  (tx_ok),
    .hold_full (tx_hold_full),
    .busy      (tx_busy),
    .line      (tx_line)
  );

  fc_rx_path #(.DATA_W(DATA_W), .BIT_CYC(BIT_CYC)) u_rx (
    .clk   (clk),
    .rst_n (rst_n_int),
    .line  (rx_line),
    .rx_en (rx_ok),
    .rd    (rx_rd),
    .data  (rx_data),
    .valid (rx_valid)
  );

  always_comb begin
    if (!fc_en)        hs_out_d = 1'b1;
    else if (out_mode) hs_out_d = ~tx_hold_full;
    else               hs_out_d = rx_valid;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) hs_out_q <= 1'b1;
    else            hs_out_q <= hs_out_d;
  end

  assign hs_out_n = hs_out_q;

endmodule

// File: rtl/fc_checker.sv
module fc_checker (
  input logic clk,
  input logic rst_n,
  input logic core_rst_n,
  input logic fc_en,
  input logic in_mode,
  input logic out_mode,
  input logic hs_in_n,
  input logic hs_out_n,
  input logic tx_hold_full,
  input logic tx_busy,
  input logic tx_line,
  input logic rx_rd,
  input logic rx_valid
);

  logic armed;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  assert_out_off_when_disabled_R9: assert property (@(posedge clk) disable iff (!core_rst_n)
    !$past(fc_en) |-> hs_out_n);

  assert_rts_tracks_hold_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
    armed && $past(fc_en) && $past(out_mode) |-> (hs_out_n == !$past(tx_hold_full)));

  assert_rtr_tracks_valid_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
    armed && $past(fc_en) && !$past(out_mode) |-> (hs_out_n == $past(rx_valid)));

  assert_start_needs_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_hold_full));

  assert_cts_synced_R10: assert property (@(posedge clk) disable iff (!core_rst_n)
    armed && $rose(tx_busy) && $past(fc_en) && !$past(in_mode) |-> !$past(hs_in_n, 3));

  assert_idle_line_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx_line);

  assert_read_clears_valid_R6: assert property (@(posedge clk) disable iff (!core_rst_n)
    $fell(rx_valid) |-> $past(rx_rd));

endmodule

bind uart_flow_ctl fc_checker u_chk (.*, .core_rst_n(rst_n_int));

// File: tb/tb_uart_flow_ctl.sv
module tb_uart_flow_ctl;

  localparam int DW = 8;
  localparam int B  = 4;
  localparam int FW = DW + 2;

  logic          clk = 1'b0;
  logic          rst_n, fc_en, in_mode, out_mode, hs_in_n;
  logic          hs_out_n, tx_wr, tx_hold_full, tx_busy, tx_line;
  logic          rx_line, rx_rd, rx_valid;
  logic [DW-1:0] tx_wdata, rx_data;
  int            checks = 0;
  int            errors = 0;

  always #2 clk = ~clk;

  uart_flow_ctl #(.DATA_W(DW), .BIT_CYC(B)) dut (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .in_mode(in_mode),
    .out_mode(out_mode), .hs_in_n(hs_in_n), .hs_out_n(hs_out_n),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_hold_full(tx_hold_full),
    .tx_busy(tx_busy), .tx_line(tx_line), .rx_line(rx_line),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  // {fc_en, out_mode, write, expected hs_out_n, expected tx_hold_full}
  localparam logic [4:0] VEC [0:5] = '{
    5'b00010, 5'b01110, 5'b10000, 5'b11010, 5'b11101, 5'b10101
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_hold(input logic [DW-1:0] v);
    tx_wr = 1'b1; tx_wdata = v;
    tick(1);
    tx_wr = 1'b0;
  endtask

  task automatic wait_busy(input string req);
    for (int n = 0; n < 60 && !tx_busy; n++) tick(1);
    chk(req, "frame start", tx_busy, 1);
  endtask

  // Called at the first negedge that shows tx_busy high.
  task automatic cap(output logic [DW-1:0] d, output logic ok);
    logic [FW-1:0] f;
    for (int j = 0; j < FW; j++) begin
      f[j] = tx_line;
      tick(B);
    end
    d  = f[DW:1];
    ok = (f[0] == 1'b0) && (f[FW-1] == 1'b1);
  endtask

  task automatic send_rx(input logic [DW-1:0] v);
    rx_line = 1'b0; tick(B);
    for (int i = 0; i < DW; i++) begin
      rx_line = v[i]; tick(B);
    end
    rx_line = 1'b1; tick(B);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    logic          ok;
    rst_n = 1'b0; fc_en = 1'b1; in_mode = 1'b0; out_mode = 1'b0;
    hs_in_n = 1'b0; tx_wr = 1'b0; tx_wdata = '0; rx_line = 1'b1; rx_rd = 1'b0;
    tick(3);
    // R1: values held during reset
    chk("R1", "hs_out_n", hs_out_n, 1);
    chk("R1", "tx_line", tx_line, 1);
    chk("R1", "tx_hold_full", tx_hold_full, 0);
    chk("R1", "tx_busy", tx_busy, 0);
    chk("R1", "rx_valid", rx_valid, 0);
    fc_en = 1'b0; hs_in_n = 1'b1;
    rst_n = 1'b1;
    tick(6);

    // Table walk: output pin role and holding-register gating
    for (int k = 0; k < 6; k++) begin
      string rq;
      fc_en = VEC[k][4]; out_mode = VEC[k][3]; in_mode = 1'b0; hs_in_n = 1'b1;
      tick(1);
      if (VEC[k][2]) write_hold(8'h40 + 8'(k));
      tick(4);
      rq = !VEC[k][4] ? "R9" : (VEC[k][3] ? "R7" : "R8");
      chk(rq, "hs_out_n", hs_out_n, VEC[k][1]);
      chk("R2", "tx_hold_full", tx_hold_full, VEC[k][0]);
      fc_en = 1'b0;
      tick(FW * B + 4);
    end

    // R2 and R10: held while clear-to-send is off, two-edge synchronizer delay
    fc_en = 1'b1; in_mode = 1'b0; out_mode = 1'b1; hs_in_n = 1'b1;
    tick(4);
    write_hold(8'hA5);
    tick(6);
    chk("R2", "busy while cts off", tx_busy, 0);
    chk("R2", "hold kept", tx_hold_full, 1);
    chk("R2", "line idle", tx_line, 1);
    hs_in_n = 1'b0;
    tick(1);
    chk("R10", "busy after 1 edge", tx_busy, 0);
    tick(1);
    chk("R10", "busy after 2 edges", tx_busy, 0);
    tick(1);
    chk("R10", "busy after 3 edges", tx_busy, 1);
    chk("R4", "hold cleared on load", tx_hold_full, 0);
    cap(d, ok);
    chk("R4", "frame data", d, 8'hA5);
    chk("R4", "start/stop", ok, 1);

    // R3: cts drops mid-frame, frame completes, next byte held
    write_hold(8'h3C);
    wait_busy("R3");
    fork
      cap(d, ok);
      begin
        tick(2 * B);
        hs_in_n = 1'b1;
        write_hold(8'h81);
      end
    join
    chk("R3", "frame data", d, 8'h3C);
    chk("R3", "start/stop", ok, 1);
    tick(6);
    chk("R2", "second byte held", tx_busy, 0);
    chk("R2", "second byte full", tx_hold_full, 1);
    chk("R7", "rts asserted", hs_out_n, 0);
    hs_in_n = 1'b0;
    wait_busy("R2");
    cap(d, ok);
    chk("R2", "released byte", d, 8'h81);
    tick(2);
    chk("R7", "rts released", hs_out_n, 1);

    // R5: enable-receiver mode
    in_mode = 1'b1; out_mode = 1'b0; hs_in_n = 1'b1;
    tick(4);
    send_rx(8'h5A);
    tick(2);
    chk("R5", "rx ignored while disabled", rx_valid, 0);
    chk("R8", "rtr asserted when empty", hs_out_n, 0);
    write_hold(8'hC3);
    wait_busy("R5");
    cap(d, ok);
    chk("R5", "tx ungated data", d, 8'hC3);
    hs_in_n = 1'b0;
    tick(4);
    send_rx(8'h96);
    tick(2);
    chk("R6", "rx valid", rx_valid, 1);
    chk("R6", "rx data", rx_data, 8'h96);
    chk("R8", "rtr released when full", hs_out_n, 1);
    rx_rd = 1'b1;
    tick(1);
    rx_rd = 1'b0;
    chk("R6", "read clears valid", rx_valid, 0);
    chk("R8", "one-cycle lag", hs_out_n, 1);
    tick(1);
    chk("R8", "rtr reasserted", hs_out_n, 0);

    // R9: flow control off
    fc_en = 1'b0; in_mode = 1'b1; hs_in_n = 1'b1;
    tick(4);
    send_rx(8'h17);
    tick(2);
    chk("R9", "rx accepted", rx_valid, 1);
    chk("R9", "rx data", rx_data, 8'h17);
    chk("R9", "hs_out_n high", hs_out_n, 1);
    rx_rd = 1'b1; tick(1); rx_rd = 1'b0;
    in_mode = 1'b0;
    write_hold(8'h6E);
    wait_busy("R9");
    cap(d, ok);
    chk("R9", "tx free-running data", d, 8'h6E);
    tick(4);
    finish_run();
  end

endmodule